// File: doc/BRIEF.md
# Quad Main/Sub DAC Register Front End

This block is the digital register side of a four-channel converter. Each channel carries a 10-bit main code and an 8-bit sub (fine trim) code. A processor reaches the block through a parallel write port with chip select, write strobe, a mode line, three address lines and a 10-bit data bus. Through this port it writes one system control register, one control register per channel, and the per-channel input registers. A load strobe copies the input registers into the output registers, and only the output registers drive the converters.

Clearing happens on three paths. The active-low hardware clear acts on every channel at once. The software system clear acts only on the main codes. The per-channel clear is applied when the next load arrives. Power-down and standby reach the converters as per-channel "on" flags, and register contents stay as they are while a channel is off. A write is sampled on the clock edge that first sees the write strobe high again after it was low, with chip select low at that edge.

Top module: `dacif_quad`

## Requirements
- R1: After reset the outputs read as follows. Every main code is 0x000 and every sub code is 0x80, which are the offset-binary clear values. offset_bin=1 and byte_mode=0. ch_on is all zero because the system is in standby. Each channel's standby control is in its "normal" state.
- R2: Write commit and decoding:
  - A write commits only with cs_n low.
  - With mode=0, din[0]=0 selects the system register and din[0]=1 selects the control register of channel addr.
  - In a channel control register, din[1] is clear, din[4] is standby-not (1 = normal), din[6:5] is the bias select (shown on ch_bias) and din[7] is the sub steering bit.
  - An address of NUM_CH or above is ignored.
- R3: System register fields: din[1] = system clear, din[2] = standby, din[3] = coding (1 = offset binary, 0 = two's complement), din[4] = byte mode, din[5] = power on. offset_bin and byte_mode show the coding and format bits.
- R4: Data writes (mode=1) in 10-bit format follow the channel's sub steering bit. With the bit at 0, the main input takes din[9:0]. With the bit at 1, the sub input takes din[9:2].
- R5: Data writes in byte format:
  - din[0]=1 writes din[9:2] to the sub input, whatever the steering bit says.
  - din[0]=0 with din[1]=0 writes din[9:2] into main bits [9:2].
  - din[0]=0 with din[1]=1 writes din[3:2] into main bits [1:0].
- R6: If ldac_n is low when a data write commits, the addressed channel's output registers take the new input value on that same edge. The other channels keep their outputs.
- R7: If ldac_n is high when a data write commits, the outputs do not change. A later falling edge of ldac_n loads the outputs of every channel from its inputs.
- R8: A channel whose clear bit is set loads main 0x000 on each load and loads its sub code normally. Once the clear bit is written back to 0, the next load restores the retained input.
- R9: While the system clear bit is set, every main output is held at 0x000. Sub outputs and all input registers are left untouched, so a load after the bit is cleared restores the earlier codes.
- R10: While clr_n is low at a clock edge, every main input and output register is set to 0x000. Every sub input and output register is set to 0x00 under two's complement coding and 0x80 under offset binary. A write that commits in the same cycle is lost.
- R11: ch_on[i] is 1 only when power is on, system standby is off and channel i's standby-not bit is 1. Power-down and standby leave every code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; commit on its rising edge |
| mode | input | 1 | 0 = control registers, 1 = data registers |
| addr | input | ADDR_W | Channel address |
| din | input | MAIN_W | Write data |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low hardware clear |
| main_code | output | NUM_CH*MAIN_W | Main output codes, channel 0 in the low bits |
| sub_code | output | NUM_CH*(MAIN_W-2) | Sub output codes, channel 0 in the low bits |
| ch_bias | output | NUM_CH*2 | Bias-source select per channel |
| ch_on | output | NUM_CH | Channel powered and out of standby |
| offset_bin | output | 1 | 1 = offset-binary coding selected |
| byte_mode | output | 1 | 1 = byte loading format selected |

## Verification
A hardware clear can land on the same edge as a committing data write that has ldac_n low, which asks for an immediate output load. The bench holds clr_n low across the whole write strobe. It then checks that the addressed main output reads the clear code right after the commit edge. It also checks that a later load pulse still gives the clear code, which shows the input register was cleared too and the write was dropped.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // control-write target select bit (mode = 0)
    localparam int SEL_BIT    = 0;

    // system register field positions
    localparam int SYS_SCLR   = 1;
    localparam int SYS_STBY   = 2;
    localparam int SYS_OFFS   = 3;
    localparam int SYS_BYTE   = 4;
    localparam int SYS_PWR    = 5;

    // channel control register field positions
    localparam int CH_CLR     = 1;
    localparam int CH_STBYN   = 4;
    localparam int CH_BIAS_LO = 5;
    localparam int CH_SUB     = 7;

    // byte-format data write steering bits
    localparam int BYTE_SUB   = 0;
    localparam int BYTE_HILO  = 1;

    typedef struct packed {
        logic byte_mode;
        logic offset_bin;
        logic pwr_on;
        logic standby;
        logic sclr;
    } sys_ctl_t;

    typedef struct packed {
        logic [1:0] bias;
        logic       sub_sel;
        logic       stby_n;
        logic       clr;
    } chan_ctl_t;

    localparam sys_ctl_t SYS_RESET = '{byte_mode: 1'b0, offset_bin: 1'b1,
                                       pwr_on: 1'b1, standby: 1'b1, sclr: 1'b0};

    localparam chan_ctl_t CH_RESET = '{bias: 2'b00, sub_sel: 1'b0,
                                       stby_n: 1'b1, clr: 1'b0};

endpackage

// File: rtl/dacif_wr_decode.sv
module dacif_wr_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_bit,
    input  logic              ldac_n,
    output logic              sys_we,
    output logic [NUM_CH-1:0] ctl_we,
    output logic [NUM_CH-1:0] dat_we,
    output logic [NUM_CH-1:0] load
);

    typedef struct packed {
        logic wr_n;
        logic ldac_n;
    } strb_t;

    strb_t st_d, st_q;
    logic  commit;
    logic  ldac_fall;

    always_comb begin
        st_d        = st_q;
        st_d.wr_n   = wr_n;
        st_d.ldac_n = ldac_n;
        commit      = !st_q.wr_n && wr_n && !cs_n;
        ldac_fall   = st_q.ldac_n && !ldac_n;
        sys_we      = commit && !mode && !sel_bit;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        always_comb begin
            hit       = commit && (addr == ADDR_W'(i));
            ctl_we[i] = hit && !mode && sel_bit;
            dat_we[i] = hit && mode;
            load[i]   = ldac_fall || (dat_we[i] && !ldac_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{wr_n: 1'b1, ldac_n: 1'b1};
        else        st_q <= st_d;
    end

    // R2: at most one register is targeted per commit
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_we, ctl_we, dat_we}));

    // R2: a strobe commits once; the next edge cannot commit again
    p_single_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|dat_we || |ctl_we || sys_we) |=> !(|dat_we || |ctl_we || sys_we));

endmodule

// File: rtl/dacif_sys_reg.sv
module dacif_sys_reg
    import dacif_pkg::*;
#(
    parameter int DIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DIN_W-1:0] din,
    output sys_ctl_t         sys_o
);

    sys_ctl_t sys_d, sys_q;

    always_comb begin
        sys_d = sys_q;
        if (we) begin
            sys_d.sclr       = din[SYS_SCLR];
            sys_d.standby    = din[SYS_STBY];
            sys_d.offset_bin = din[SYS_OFFS];
            sys_d.byte_mode  = din[SYS_BYTE];
            sys_d.pwr_on     = din[SYS_PWR];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sys_q <= SYS_RESET;
        else        sys_q <= sys_d;
    end

    assign sys_o = sys_q;

    // R3: the system register changes only through a system write
    p_sys_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(sys_o));

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
    import dacif_pkg::*;
#(
    parameter int MAIN_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                dat_we,
    input  logic                load,
    input  logic [MAIN_W-1:0]   din,
    input  logic                byte_mode,
    input  logic                offset_bin,
    input  logic                sclr,
    input  logic                hw_clr,
    output logic [MAIN_W-1:0]   main_o,
    output logic [MAIN_W-3:0]   sub_o,
    output chan_ctl_t           ctl_o
);

    localparam int LOW_W = 2;
    localparam int SUB_W = MAIN_W - LOW_W;
    localparam logic [MAIN_W-1:0] MAIN_CLR = '0;
    localparam logic [SUB_W-1:0]  SUB_MID  = {1'b1, {(SUB_W-1){1'b0}}};

    typedef struct packed {
        chan_ctl_t         ctl;
        logic [MAIN_W-1:0] main_in;
        logic [SUB_W-1:0]  sub_in;
        logic [MAIN_W-1:0] main_out;
        logic [SUB_W-1:0]  sub_out;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic [SUB_W-1:0] sub_clr;

    always_comb begin
        s_d     = s_q;
        sub_clr = offset_bin ? SUB_MID : '0;

        if (ctl_we) begin
            s_d.ctl.bias    = din[CH_BIAS_LO+1:CH_BIAS_LO];
            s_d.ctl.sub_sel = din[CH_SUB];
            s_d.ctl.stby_n  = din[CH_STBYN];
            s_d.ctl.clr     = din[CH_CLR];
        end

        if (dat_we) begin
            if (byte_mode) begin
                if (din[BYTE_SUB])
                    s_d.sub_in = din[MAIN_W-1:LOW_W];
                else if (din[BYTE_HILO])
                    s_d.main_in[LOW_W-1:0] = din[2*LOW_W-1:LOW_W];
                else
                    s_d.main_in[MAIN_W-1:LOW_W] = din[MAIN_W-1:LOW_W];
            end else if (s_q.ctl.sub_sel) begin
                s_d.sub_in = din[MAIN_W-1:LOW_W];
            end else begin
                s_d.main_in = din;
            end
        end

        if (load) begin
            s_d.main_out = s_q.ctl.clr ? MAIN_CLR : s_d.main_in;
            s_d.sub_out  = s_d.sub_in;
        end

        if (sclr)
            s_d.main_out = MAIN_CLR;

        if (hw_clr) begin
            s_d.main_in  = MAIN_CLR;
            s_d.main_out = MAIN_CLR;
            s_d.sub_in   = sub_clr;
            s_d.sub_out  = sub_clr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctl      <= CH_RESET;
            s_q.main_in  <= MAIN_CLR;
            s_q.sub_in   <= SUB_MID;
            s_q.main_out <= MAIN_CLR;
            s_q.sub_out  <= SUB_MID;
        end else begin
            s_q <= s_d;
        end
    end

    assign main_o = s_q.main_out;
    assign sub_o  = s_q.sub_out;
    assign ctl_o  = s_q.ctl;

    // R10: hardware clear empties the main path, input included
    p_hwclr_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> (main_o == '0) && (s_q.main_in == '0));

    // R9: system clear pins the main output, leaves the sub output alone
    p_sclr_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> main_o == '0);

    p_sclr_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclr && !load && !hw_clr) |=> $stable(sub_o));

    // R7: without load or clear, the outputs hold
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sclr && !hw_clr) |=> ($stable(main_o) && $stable(sub_o)));

    // R8: a load on a cleared channel gives the main clear code
    p_chclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && s_q.ctl.clr) |=> main_o == '0);

endmodule

// File: rtl/dacif_quad.sv
module dacif_quad
    import dacif_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3,
    parameter int MAIN_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          wr_n,
    input  logic                          mode,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [MAIN_W-1:0]             din,
    input  logic                          ldac_n,
    input  logic                          clr_n,
    output logic [NUM_CH*MAIN_W-1:0]      main_code,
    output logic [NUM_CH*(MAIN_W-2)-1:0]  sub_code,
    output logic [NUM_CH*2-1:0]           ch_bias,
    output logic [NUM_CH-1:0]             ch_on,
    output logic                          offset_bin,
    output logic                          byte_mode
);

    localparam int SUB_W = MAIN_W - 2;

    logic              sys_we;
    logic [NUM_CH-1:0] ctl_we;
    logic [NUM_CH-1:0] dat_we;
    logic [NUM_CH-1:0] load;
    sys_ctl_t          sys;

    dacif_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .mode   (mode),
        .addr   (addr),
        .sel_bit(din[SEL_BIT]),
        .ldac_n (ldac_n),
        .sys_we (sys_we),
        .ctl_we (ctl_we),
        .dat_we (dat_we),
        .load   (load)
    );

    dacif_sys_reg #(.DIN_W(MAIN_W)) u_sys (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (sys_we),
        .din  (din),
        .sys_o(sys)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        chan_ctl_t ctl;

        dacif_chan #(.MAIN_W(MAIN_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we[i]),
            .dat_we    (dat_we[i]),
            .load      (load[i]),
            .din       (din),
            .byte_mode (sys.byte_mode),
            .offset_bin(sys.offset_bin),
            .sclr      (sys.sclr),
            .hw_clr    (!clr_n),
            .main_o    (main_code[i*MAIN_W +: MAIN_W]),
            .sub_o     (sub_code[i*SUB_W +: SUB_W]),
            .ctl_o     (ctl)
        );

        always_comb begin
            ch_on[i]         = sys.pwr_on && !sys.standby && ctl.stby_n;
            ch_bias[i*2 +: 2] = ctl.bias;
        end
    end

    assign offset_bin = sys.offset_bin;
    assign byte_mode  = sys.byte_mode;

    // R11: power state changes never disturb the codes on their own
    p_pwr_keeps_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_we && load == '0 && !sys.sclr && clr_n) |=> $stable(main_code) && $stable(sub_code));

endmodule

// File: tb/dacif_quad_tb.sv
module dacif_quad_tb_top;

    localparam int NCH = 4;
    localparam int MW  = 10;
    localparam int SW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1, wr_n = 1'b1, mode = 1'b0;
    logic [2:0]      addr = '0;
    logic [MW-1:0]   din = '0;
    logic            ldac_n = 1'b1, clr_n = 1'b1;
    logic [NCH*MW-1:0] main_code;
    logic [NCH*SW-1:0] sub_code;
    logic [NCH*2-1:0]  ch_bias;
    logic [NCH-1:0]    ch_on;
    logic              offset_bin, byte_mode;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dacif_quad dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
        .addr(addr), .din(din), .ldac_n(ldac_n), .clr_n(clr_n),
        .main_code(main_code), .sub_code(sub_code), .ch_bias(ch_bias),
        .ch_on(ch_on), .offset_bin(offset_bin), .byte_mode(byte_mode)
    );

    // {mode, addr, din, ldac_n, check channel, exp main, exp sub, req}
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 3'd0, 10'h011, 1'b0, 2'd0, 10'h000, 8'h80, 4'd2},  // R2 steer main
        {1'b1, 3'd0, 10'h2A5, 1'b0, 2'd0, 10'h2A5, 8'h80, 4'd4},  // R4 main write
        {1'b0, 3'd0, 10'h091, 1'b0, 2'd0, 10'h2A5, 8'h80, 4'd2},  // R2 steer sub
        {1'b1, 3'd0, 10'h3C4, 1'b0, 2'd0, 10'h2A5, 8'hF1, 4'd4},  // R4 sub write
        {1'b0, 3'd1, 10'h011, 1'b0, 2'd1, 10'h000, 8'h80, 4'd2},
        {1'b1, 3'd1, 10'h155, 1'b0, 2'd1, 10'h155, 8'h80, 4'd6},  // R6 immediate
        {1'b1, 3'd2, 10'h0FF, 1'b0, 2'd2, 10'h0FF, 8'h80, 4'd6},
        {1'b1, 3'd3, 10'h3FF, 1'b0, 2'd0, 10'h2A5, 8'hF1, 4'd6}   // R6 others keep
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ch(string tag, int ch, logic [MW-1:0] em, logic [SW-1:0] es);
        chk($sformatf("%s main ch%0d", tag, ch), 32'(main_code[ch*MW +: MW]), 32'(em));
        chk($sformatf("%s sub ch%0d", tag, ch), 32'(sub_code[ch*SW +: SW]), 32'(es));
    endtask

    task automatic do_wr(logic m, logic [2:0] a, logic [MW-1:0] d, logic ld, logic cs = 1'b0);
        @(negedge clk);
        cs_n = cs; mode = m; addr = a; din = d; ldac_n = ld; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic pulse_ldac();
        @(negedge clk); ldac_n = 1'b1;
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) chk_ch("R1 reset", c, 10'h000, 8'h80);
        chk("R1 ch_on", 32'(ch_on), 32'h0);
        chk("R1 offset_bin", 32'(offset_bin), 32'h1);
        chk("R1 byte_mode", 32'(byte_mode), 32'h0);

        // R3 / R11 system setup: 10-bit, two's complement, running
        do_wr(1'b0, 3'd0, 10'h020, 1'b1);
        chk("R3 offset_bin", 32'(offset_bin), 32'h0);
        chk("R11 ch_on running", 32'(ch_on), 32'hF);

        // table walk: R2 R4 R6
        for (int v = 0; v < NV; v++) begin
            do_wr(VEC[v][38], VEC[v][37:35], VEC[v][34:25], VEC[v][24]);
            chk_ch($sformatf("R%0d vec%0d", VEC[v][3:0], v), int'(VEC[v][23:22]),
                   VEC[v][21:12], VEC[v][11:4]);
        end

        // R2 chip select high: write ignored
        do_wr(1'b1, 3'd2, 10'h111, 1'b0, 1'b1);
        chk_ch("R2 cs_n high", 2, 10'h0FF, 8'h80);
        // R2 out-of-range address ignored (ch0 would take sub 0x00)
        do_wr(1'b1, 3'd4, 10'h000, 1'b0);
        chk_ch("R2 addr 4", 0, 10'h2A5, 8'hF1);

        // R7 deferred load
        do_wr(1'b1, 3'd2, 10'h2AA, 1'b1);
        chk_ch("R7 deferred", 2, 10'h0FF, 8'h80);
        do_wr(1'b1, 3'd3, 10'h001, 1'b1);
        chk_ch("R7 deferred", 3, 10'h3FF, 8'h80);
        pulse_ldac();
        chk_ch("R7 loaded", 2, 10'h2AA, 8'h80);
        chk_ch("R7 loaded", 3, 10'h001, 8'h80);
        chk_ch("R7 loaded", 0, 10'h2A5, 8'hF1);

        // R8 channel clear waits for load
        do_wr(1'b0, 3'd1, 10'h013, 1'b1);
        do_wr(1'b1, 3'd1, 10'h200, 1'b1);
        chk_ch("R8 before load", 1, 10'h155, 8'h80);
        pulse_ldac();
        chk_ch("R8 cleared", 1, 10'h000, 8'h80);
        do_wr(1'b0, 3'd1, 10'h011, 1'b1);
        pulse_ldac();
        chk_ch("R8 restored", 1, 10'h200, 8'h80);

        // R9 system clear: main only, inputs kept
        do_wr(1'b0, 3'd0, 10'h022, 1'b1);
        @(negedge clk);
        chk_ch("R9 sclr", 0, 10'h000, 8'hF1);
        chk_ch("R9 sclr", 3, 10'h000, 8'h80);
        do_wr(1'b0, 3'd0, 10'h020, 1'b1);
        pulse_ldac();
        chk_ch("R9 restored", 2, 10'h2AA, 8'h80);
        chk_ch("R9 restored", 0, 10'h2A5, 8'hF1);

        // R11 power flags and bias field (R2)
        do_wr(1'b0, 3'd3, 10'h061, 1'b1);
        chk("R11 ch3 standby", 32'(ch_on), 32'h7);
        chk("R2 ch3 bias", 32'(ch_bias[7:6]), 32'h3);
        do_wr(1'b0, 3'd0, 10'h000, 1'b1);
        chk("R11 power down", 32'(ch_on), 32'h0);
        chk_ch("R11 codes kept", 2, 10'h2AA, 8'h80);
        do_wr(1'b0, 3'd0, 10'h024, 1'b1);
        chk("R11 system standby", 32'(ch_on), 32'h0);
        do_wr(1'b0, 3'd0, 10'h020, 1'b1);
        chk("R11 resumed", 32'(ch_on), 32'h7);

        // R5 byte format
        do_wr(1'b0, 3'd0, 10'h030, 1'b1);
        chk("R5 byte_mode", 32'(byte_mode), 32'h1);
        do_wr(1'b1, 3'd0, 10'h294, 1'b0);
        chk_ch("R5 high byte", 0, 10'h295, 8'hF1);
        do_wr(1'b1, 3'd0, 10'h00A, 1'b0);
        chk_ch("R5 low bits", 0, 10'h296, 8'hF1);
        do_wr(1'b1, 3'd0, 10'h0F1, 1'b0);
        chk_ch("R5 sub byte", 0, 10'h296, 8'h3C);
        do_wr(1'b1, 3'd1, 10'h0F1, 1'b0);
        chk_ch("R5 sub ignores steering", 1, 10'h200, 8'h3C);

        // R10 hardware clear, both codings
        pulse_clr();
        chk_ch("R10 twos clear", 0, 10'h000, 8'h00);
        chk_ch("R10 twos clear", 3, 10'h000, 8'h00);
        do_wr(1'b0, 3'd0, 10'h038, 1'b0);
        chk("R3 offset_bin set", 32'(offset_bin), 32'h1);
        pulse_clr();
        chk_ch("R10 offset clear", 2, 10'h000, 8'h80);

        // R10 clear collides with a committing immediate-load write
        @(negedge clk); clr_n = 1'b0;
        do_wr(1'b1, 3'd2, 10'h294, 1'b0);
        chk_ch("R10 collision", 2, 10'h000, 8'h80);
        clr_n = 1'b1;
        pulse_ldac();
        chk_ch("R10 write lost", 2, 10'h000, 8'h80);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule